// File: doc/BRIEF.md
# Two-Port Audio Interrupt Controller

This block gathers the interrupt requests of a two-port audio serial unit into one CPU interrupt line. Each port has an output (playback) request and an input (capture) request, giving four sources. A rising edge on a source request latches a status bit. Each source then passes through two separate gates, a mask register and an enable-mask register, and only a source that both gates let through can raise the CPU line.

Software sees four 24-bit registers through a plain write strobe with address and data, and reads them combinationally by address. The registers are status, mask, enable mask and soft reset. Status bits are cleared by writing zeros to them. The CPU line is a latched request with its own clear, a rising interrupt-reset bit in the soft-reset register, so the handler can drop the line without touching status. Per-port reset bits clear that port's status bits, and a global reset bit clears the whole interrupt state.

Top module: `audio_irq_hub`

## Requirements
- R1: After the hardware reset `rstN` goes low, every register reads 0 and `cpuIrq` is low.
- R2: Source i (0 port A out, 1 port A in, 2 port B out, 3 port B in) owns status bit 4*i (bits 0, 4, 8, 12 of address 0). A source sets its bit on a 0-to-1 transition of `srcReq[i]` sampled at a clock edge. The bit stays set while the request holds or drops, and a request held high never sets it again.
- R3: A write to status (address 0) clears each source bit whose data bit at 4*i is 0 and leaves bits written 1 unchanged, so an all-zero write clears all four. Such a write never sets a bit, and unassigned status bits read 0.
- R4: A source edge in the same cycle as a status write or a port reset that would clear its bit wins, and the bit ends set.
- R5: The mask register (address 1) and the enable-mask register (address 2) gate source i with bit 4*i. The latched request behind `cpuIrq` is set one cycle after a source's status bit, mask bit and enable-mask bit first all become 1, whichever of the three is the last. It is never set for a source missing any of them.
- R6: Writing soft reset (address 3) with bit 4 at 1 while its stored bit 4 is 0 clears the latched request and leaves status unchanged. A source that newly becomes active in that same cycle, or later, sets the request again.
- R7: A 0-to-1 write of soft-reset bit 8 clears the port A status bits (0 and 4). A 0-to-1 write of bit 12 clears the port B bits (8 and 12). The other port is untouched.
- R8: A 0-to-1 write of soft-reset bit 0 clears status, mask, enable mask and the latched request. This wins even over a source edge in the same cycle.
- R9: Each write keeps only data bits 23:0. Every register reads back with bits 31:24 at 0, and the soft-reset register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| srcReq | input | 4 | Source requests: A out, A in, B out, B in |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register address: 0 status, 1 mask, 2 enable mask, 3 soft reset |
| wrData | input | 32 | Write data; bits 31:24 are discarded |
| rdData | output | 32 | Combinational read data of the addressed register |
| cpuIrq | output | 1 | Latched interrupt request to the CPU |

## Verification
The hardest cases to reach are same-cycle collisions, where a source edge lands in the very clock that a clearing write or a reset pulse takes effect. The stimulus drives `srcReq` and the write strobe together at one falling edge so that both hit the same rising edge. It then reads status back to see which side won. A second subtle case is a request raised by enabling a gate after the status bit was already latched, and one raised again by a new source just after the interrupt-reset bit dropped the line. The stimulus reaches these by ordering mask writes, pulses and soft-reset writes so that each gate is closed or open at a known time.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

  // register addresses
  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_MASK   = 1;
  localparam int unsigned REG_ENMASK = 2;
  localparam int unsigned REG_SOFT   = 3;

  // soft-reset register bit positions
  localparam int unsigned SOFT_ALL_BIT  = 0;
  localparam int unsigned SOFT_INT_BIT  = 4;
  localparam int unsigned SOFT_PORTA_BIT = 8;
  localparam int unsigned SOFT_PORTB_BIT = 12;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic wrEnMask;
    logic intReset;
    logic portAReset;
    logic portBReset;
    logic allReset;
  } strobe_t;

endpackage

// File: rtl/audio_irq_ctrl.sv
module audio_irq_ctrl
  import audio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned KEEP_W = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [KEEP_W-1:0] wrData,
  output strobe_t           strb,
  output logic [KEEP_W-1:0] softQ
);

  logic wrSoft;

  assign wrSoft = wrEn && (addr == ADDR_W'(REG_SOFT));

  // a reset action fires when a stored 0 is overwritten with 1
  always_comb begin
    strb            = '0;
    strb.wrStatus   = wrEn && (addr == ADDR_W'(REG_STATUS));
    strb.wrMask     = wrEn && (addr == ADDR_W'(REG_MASK));
    strb.wrEnMask   = wrEn && (addr == ADDR_W'(REG_ENMASK));
    strb.allReset   = wrSoft && wrData[SOFT_ALL_BIT]   && !softQ[SOFT_ALL_BIT];
    strb.intReset   = wrSoft && wrData[SOFT_INT_BIT]   && !softQ[SOFT_INT_BIT];
    strb.portAReset = wrSoft && wrData[SOFT_PORTA_BIT] && !softQ[SOFT_PORTA_BIT];
    strb.portBReset = wrSoft && wrData[SOFT_PORTB_BIT] && !softQ[SOFT_PORTB_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softQ <= '0;
    end else if (wrSoft) begin
      softQ <= wrData;
    end
  end

endmodule

// File: rtl/audio_irq_dp.sv
module audio_irq_dp
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 4,
  parameter int unsigned SRC_STRIDE = 4,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned KEEP_W     = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  strobe_t            strb,
  input  logic [KEEP_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [KEEP_W-1:0]  softQ,
  output logic [KEEP_W-1:0]  rdWord,
  output logic               cpuIrq,
  output logic [NUM_SRC-1:0] statusVec,
  output logic [NUM_SRC-1:0] gateVec,
  output logic [NUM_SRC-1:0] evtVec
);

  localparam int unsigned HALF_SRC = NUM_SRC / 2;

  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] actPrev;
  logic [NUM_SRC-1:0] activeVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [KEEP_W-1:0]  maskQ;
  logic [KEEP_W-1:0]  enMaskQ;
  logic [KEEP_W-1:0]  statusWord;
  logic               pendQ;

  assign evtVec    = srcReq & ~srcPrev;
  assign activeVec = statusQ & gateVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic portClr;
    if (i < HALF_SRC) begin : g_portA
      assign portClr = strb.portAReset;
    end else begin : g_portB
      assign portClr = strb.portBReset;
    end
    assign gateVec[i] = maskQ[i*SRC_STRIDE] & enMaskQ[i*SRC_STRIDE];
    assign clrVec[i]  = (strb.wrStatus & ~wrData[i*SRC_STRIDE]) | portClr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev <= '0;
      statusQ <= '0;
      actPrev <= '0;
      maskQ   <= '0;
      enMaskQ <= '0;
      pendQ   <= 1'b0;
    end else begin
      srcPrev <= srcReq;
      if (strb.allReset) begin
        statusQ <= '0;
        actPrev <= '0;
        maskQ   <= '0;
        enMaskQ <= '0;
        pendQ   <= 1'b0;
      end else begin
        statusQ <= (statusQ & ~clrVec) | evtVec;
        actPrev <= activeVec;
        if (strb.wrMask)   maskQ   <= wrData;
        if (strb.wrEnMask) enMaskQ <= wrData;
        if (|(activeVec & ~actPrev)) pendQ <= 1'b1;
        else if (strb.intReset)      pendQ <= 1'b0;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < NUM_SRC; i++) statusWord[i*SRC_STRIDE] = statusQ[i];
  end

  always_comb begin
    case (addr)
      ADDR_W'(REG_STATUS): rdWord = statusWord;
      ADDR_W'(REG_MASK):   rdWord = maskQ;
      ADDR_W'(REG_ENMASK): rdWord = enMaskQ;
      default:             rdWord = softQ;
    endcase
  end

  assign cpuIrq    = pendQ;
  assign statusVec = statusQ;

endmodule

// File: rtl/audio_irq_hub.sv
module audio_irq_hub
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 4,
  parameter int unsigned SRC_STRIDE = 4,
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned BUS_W      = 32,
  parameter int unsigned KEEP_W     = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wrData,
  output logic [BUS_W-1:0]   rdData,
  output logic               cpuIrq
);

  localparam int unsigned DROP_W = BUS_W - KEEP_W;

  strobe_t            strb;
  logic [KEEP_W-1:0]  softQ;
  logic [KEEP_W-1:0]  rdWord;
  logic [NUM_SRC-1:0] statusVec;
  logic [NUM_SRC-1:0] gateVec;
  logic [NUM_SRC-1:0] evtVec;
  logic               unusedHi;

  assign unusedHi = ^wrData[BUS_W-1:KEEP_W];

  audio_irq_ctrl #(.ADDR_W(ADDR_W), .KEEP_W(KEEP_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData[KEEP_W-1:0]),
    .strb   (strb),
    .softQ  (softQ)
  );

  audio_irq_dp #(
    .NUM_SRC(NUM_SRC), .SRC_STRIDE(SRC_STRIDE), .ADDR_W(ADDR_W), .KEEP_W(KEEP_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .srcReq    (srcReq),
    .strb      (strb),
    .wrData    (wrData[KEEP_W-1:0]),
    .addr      (addr),
    .softQ     (softQ),
    .rdWord    (rdWord),
    .cpuIrq    (cpuIrq),
    .statusVec (statusVec),
    .gateVec   (gateVec),
    .evtVec    (evtVec)
  );

  assign rdData = {{DROP_W{1'b0}}, rdWord};

endmodule

// File: rtl/audio_irq_chk.sv
module audio_irq_chk
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               cpuIrq,
  input strobe_t            strb,
  input logic [NUM_SRC-1:0] statusVec,
  input logic [NUM_SRC-1:0] gateVec,
  input logic [NUM_SRC-1:0] evtVec
);

  logic [NUM_SRC-1:0] seenAct;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              seenAct <= '0;
    else if (strb.allReset) seenAct <= '0;
    else                    seenAct <= statusVec & gateVec;
  end

  // R5: the line only rises after a fully gated source was active
  a_r5_irq_needs_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuIrq) |-> $past(|(statusVec & gateVec)));

  // R6: interrupt reset with no new activation drops the line
  a_r6_intreset_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.intReset && !strb.allReset && ((statusVec & gateVec & ~seenAct) == '0))
    |=> !cpuIrq);

  // R8: global reset empties status and the line
  a_r8_global_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.allReset |=> (!cpuIrq && (statusVec == '0) && (gateVec == '0)));

  // R4: a source edge always lands in status unless global reset
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtVec) && !strb.allReset) |=> ((statusVec & $past(evtVec)) == $past(evtVec)));

  // R3: a status write never sets a bit by itself
  a_r3_write_only_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus && (evtVec == '0)) |=> ((statusVec & ~$past(statusVec)) == '0));

endmodule

bind audio_irq_hub audio_irq_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuIrq    (cpuIrq),
  .strb      (strb),
  .statusVec (statusVec),
  .gateVec   (gateVec),
  .evtVec    (evtVec)
);

// File: tb/tb_audio_irq_hub.sv
module tb_audio_irq_hub;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcReq = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cpuIrq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  audio_irq_hub dut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .cpuIrq(cpuIrq)
  );

  typedef struct packed {
    logic        isWr;
    logic [1:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 2'd0, 32'h0,        32'h0},
    '{1'b0, 2'd1, 32'h0,        32'h0},
    '{1'b0, 2'd3, 32'h0,        32'h0},
    '{1'b1, 2'd1, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 2'd1, 32'h0,        32'h00FFFFFF},
    '{1'b1, 2'd2, 32'hA5123456, 32'h0},
    '{1'b0, 2'd2, 32'h0,        32'h00123456},
    '{1'b1, 2'd0, 32'hFFFFFFFF, 32'h0},
    '{1'b0, 2'd0, 32'h0,        32'h0},
    '{1'b1, 2'd3, 32'hFF000001, 32'h0},
    '{1'b0, 2'd3, 32'h0,        32'h00000001},
    '{1'b0, 2'd1, 32'h0,        32'h0},
    '{1'b0, 2'd2, 32'h0,        32'h0},
    '{1'b1, 2'd3, 32'h0,        32'h0},
    '{1'b0, 2'd3, 32'h0,        32'h0},
    '{1'b0, 2'd0, 32'h0,        32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    srcReq = srcReq | m;
    @(negedge clk);
    srcReq = srcReq & ~m;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 irq low in reset", {31'b0, cpuIrq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table: reset values, 24-bit keep, global reset clears masks
    for (int k = 0; k < NVEC; k++) begin
      if (TBL[k].isWr) wr(TBL[k].a, TBL[k].d);
      else rd($sformatf("R1/R8/R9 table entry %0d", k), TBL[k].a, TBL[k].exp);
    end

    // R5 gating: source 3 enabled in mask only
    wr(2'd1, 32'h1111);
    wr(2'd2, 32'h0111);
    pulse(4'b1000);
    @(negedge clk);
    rd("R2 src3 at bit12", 2'd0, 32'h1000);
    chk("R5 no irq without enable mask", {31'b0, cpuIrq}, 32'h0);
    pulse(4'b0001);
    rd("R2 src0 at bit0", 2'd0, 32'h1001);
    chk("R5 irq one cycle late", {31'b0, cpuIrq}, 32'h0);
    @(negedge clk);
    chk("R5 irq raised", {31'b0, cpuIrq}, 32'h1);

    // R6 interrupt reset
    wr(2'd3, 32'h10);
    chk("R6 irq dropped", {31'b0, cpuIrq}, 32'h0);
    rd("R6 status kept", 2'd0, 32'h1001);
    wr(2'd3, 32'h0);
    pulse(4'b0010);
    @(negedge clk);
    chk("R6 new source reraises", {31'b0, cpuIrq}, 32'h1);

    // R3 masked clear
    rd("R2 src1 at bit4", 2'd0, 32'h1011);
    wr(2'd0, 32'hFFFFEF);
    rd("R3 clear only bit4", 2'd0, 32'h1001);
    wr(2'd0, 32'h0);
    rd("R3 zero clears all", 2'd0, 32'h0);

    // R4 edge wins over clear; R2 level does not retrigger
    @(negedge clk);
    wrEn = 1'b1; addr = 2'd0; wrData = 32'h0; srcReq[2] = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    rd("R4 edge beats status clear", 2'd0, 32'h100);
    wr(2'd0, 32'h0);
    rd("R2 held level no reset", 2'd0, 32'h0);
    srcReq[2] = 1'b0;

    // R7 port resets
    pulse(4'b1111);
    rd("R2 all four", 2'd0, 32'h1111);
    wr(2'd3, 32'h100);
    rd("R7 port A reset", 2'd0, 32'h1100);
    wr(2'd3, 32'h1100);
    rd("R7 port B reset", 2'd0, 32'h0);
    wr(2'd3, 32'h0);
    @(negedge clk);
    srcReq[0] = 1'b1; wrEn = 1'b1; addr = 2'd3; wrData = 32'h100;
    @(negedge clk);
    wrEn = 1'b0; srcReq[0] = 1'b0;
    rd("R4 edge beats port reset", 2'd0, 32'h1);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h0);

    // R5 gate opened after status latched
    wr(2'd3, 32'h10);
    wr(2'd3, 32'h0);
    chk("R6 line idle", {31'b0, cpuIrq}, 32'h0);
    pulse(4'b1000);
    @(negedge clk);
    chk("R5 src3 still gated", {31'b0, cpuIrq}, 32'h0);
    wr(2'd2, 32'h1111);
    @(negedge clk);
    chk("R5 raise on late enable", {31'b0, cpuIrq}, 32'h1);

    // R8 global reset beats same-cycle edge
    @(negedge clk);
    srcReq[2] = 1'b1; wrEn = 1'b1; addr = 2'd3; wrData = 32'h1;
    @(negedge clk);
    wrEn = 1'b0; srcReq[2] = 1'b0;
    chk("R8 irq cleared", {31'b0, cpuIrq}, 32'h0);
    rd("R8 status cleared", 2'd0, 32'h0);
    rd("R8 mask cleared", 2'd1, 32'h0);
    rd("R8 enable mask cleared", 2'd2, 32'h0);
    rd("R9 soft readback", 2'd3, 32'h1);
    wr(2'd3, 32'h0);

    // R1 hardware reset clears registers
    wr(2'd1, 32'h55);
    wr(2'd3, 32'h800);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    rd("R1 mask after reset", 2'd1, 32'h0);
    rd("R1 soft after reset", 2'd3, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule